// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block is the digital back end of a power-supply supervisor. An external comparator, already synchronised into the block's clock domain, reports whether the monitored supply is below its trip level. The block turns that flag into a system reset. It rejects undervoltage dips that are too short to matter. It asserts reset once a dip lasts long enough. After the supply recovers, it keeps reset asserted for a long minimum time.

All timing is counted in cycles of the free-running clock. The glitch window and the release timeout are parameters. With the defaults at 250 MHz, the window is about 20 us and the timeout about 240 ms. A build-time option selects whether the reset pin is active-high or active-low. The core works on a single internal "reset active" state, and only the last stage applies the polarity.

Top module: `supply_reset_seq`

## Requirements
- R1: While reset is active, a cycle that samples `sup_low` = 1 keeps reset active in the next cycle, so reset is never released while the supply is low.
- R2: Reset is released only after `HOLD_CYCLES` consecutive clock edges that sample `sup_low` = 0. The release is visible right after the edge that takes the last of those samples.
- R3: While reset is released, a run of fewer than `FILT_CYCLES` consecutive samples with `sup_low` = 1 leaves reset released. A single sample with `sup_low` = 0 clears the run.
- R4: While reset is released, `FILT_CYCLES` consecutive samples with `sup_low` = 1 make reset active right after the edge that takes the last of them. This bounds the trip latency to `FILT_CYCLES` cycles.
- R5: A sample with `sup_low` = 1 during the release timeout restarts the timeout from zero. Another full `HOLD_CYCLES` of good samples is then needed.
- R6: While `rst_n` is low, reset is active. After `rst_n` rises, the block behaves as though the supply had just recovered: reset stays active for the full timeout.
- R7: With `ACTIVE_HIGH` = 1, `sys_rst` is 1 when reset is active. With `ACTIVE_HIGH` = 0, `sys_rst` is 0 when reset is active. The pin carries the same internal state in both variants, and only its sense differs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running timebase clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset of the logic |
| sup_low | input | 1 | Synchronised comparator flag, 1 = supply below trip level |
| sys_rst | output | 1 | System reset, sense chosen by `ACTIVE_HIGH` |

## Verification
A stuck or miscounted internal state shows up directly as a wrong level on `sys_rst`.

- A glitch counter that fails to clear makes reset trip on a short dip, one cycle after the offending edge.
- A hold counter that fails to clear on a dip releases reset early, up to a full timeout ahead of time.
- A wrong polarity stage inverts the pin from the first cycle.

The bench keeps its own cycle model of the trip and release rules and compares the pin on every clock, so any such divergence is caught in the cycle it first appears.

// File: rtl/supsv_pkg.sv
package supsv_pkg;

   // Two-state controller: reset held (active) or released.
   typedef enum logic {
      SV_HOLDING  = 1'b0,
      SV_RELEASED = 1'b1
   } supsv_state_e;

   // Bits needed to hold counts 0..n.
   function automatic int unsigned supsv_cnt_bits(input int unsigned n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/supsv_glitch_filter.sv
module supsv_glitch_filter
   import supsv_pkg::*;
#(
   parameter int unsigned FILT_CYCLES = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic sup_low,
   output logic trip
);

   generate
      if (FILT_CYCLES == 1) begin : g_direct
         // Window of one sample: any low sample trips at once.
         assign trip = armed & sup_low;
      end else begin : g_counted
         localparam int unsigned CW = supsv_cnt_bits(FILT_CYCLES);
         localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

         logic [CW-1:0] run_q;

         assign trip = armed & sup_low & (run_q == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q <= '0;
            end else if (!armed || !sup_low || trip) begin
               run_q <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/supsv_hold_timer.sv
module supsv_hold_timer
   import supsv_pkg::*;
#(
   parameter int unsigned HOLD_CYCLES = 60000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic sup_low,
   output logic done
);

   generate
      if (HOLD_CYCLES == 1) begin : g_direct
         assign done = armed & ~sup_low;
      end else begin : g_counted
         localparam int unsigned CW = supsv_cnt_bits(HOLD_CYCLES);
         localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

         logic [CW-1:0] good_q;

         assign done = armed & ~sup_low & (good_q == LAST);

         // Any low sample restarts the timeout.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               good_q <= '0;
            end else if (!armed || sup_low || done) begin
               good_q <= '0;
            end else begin
               good_q <= good_q + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/supsv_ctrl.sv
module supsv_ctrl
   import supsv_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic trip,
   input  logic done,
   output logic hold_armed,
   output logic filt_armed,
   output logic rst_act
);

   supsv_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SV_HOLDING:  if (done) state_d = SV_RELEASED;
         SV_RELEASED: if (trip) state_d = SV_HOLDING;
         default:     state_d = SV_HOLDING;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SV_HOLDING;
      end else begin
         state_q <= state_d;
      end
   end

   assign hold_armed = (state_q == SV_HOLDING);
   assign filt_armed = (state_q == SV_RELEASED);
   assign rst_act    = (state_q == SV_HOLDING);

endmodule

// File: rtl/supsv_out_drive.sv
module supsv_out_drive #(
   parameter bit ACTIVE_HIGH = 1'b0
) (
   input  logic rst_act,
   output logic sys_rst
);

   generate
      if (ACTIVE_HIGH) begin : g_high
         assign sys_rst = rst_act;
      end else begin : g_low
         assign sys_rst = ~rst_act;
      end
   endgenerate

endmodule

// File: rtl/supply_reset_seq.sv
module supply_reset_seq #(
   parameter int unsigned FILT_CYCLES = 5000,
   parameter int unsigned HOLD_CYCLES = 60000000,
   parameter bit          ACTIVE_HIGH = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sup_low,
   output logic sys_rst
);

   generate
      if (FILT_CYCLES < 1) begin : g_bad_filt
         $error("supply_reset_seq: FILT_CYCLES must be at least 1");
      end
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("supply_reset_seq: HOLD_CYCLES must be at least 1");
      end
   endgenerate

   logic trip;
   logic done;
   logic hold_armed;
   logic filt_armed;
   logic rst_act;

   supsv_glitch_filter #(
      .FILT_CYCLES (FILT_CYCLES)
   ) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .armed   (filt_armed),
      .sup_low (sup_low),
      .trip    (trip)
   );

   supsv_hold_timer #(
      .HOLD_CYCLES (HOLD_CYCLES)
   ) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .armed   (hold_armed),
      .sup_low (sup_low),
      .done    (done)
   );

   supsv_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .trip       (trip),
      .done       (done),
      .hold_armed (hold_armed),
      .filt_armed (filt_armed),
      .rst_act    (rst_act)
   );

   supsv_out_drive #(
      .ACTIVE_HIGH (ACTIVE_HIGH)
   ) u_drv (
      .rst_act (rst_act),
      .sys_rst (sys_rst)
   );

endmodule

// File: rtl/supsv_checker.sv
module supsv_checker #(
   parameter int unsigned FILT_CYCLES = 5000,
   parameter int unsigned HOLD_CYCLES = 60000000,
   parameter bit          ACTIVE_HIGH = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic sup_low,
   input logic rst_act,
   input logic sys_rst
);

   localparam int unsigned LW = $clog2(FILT_CYCLES + 2);
   localparam int unsigned HW = $clog2(HOLD_CYCLES + 2);
   localparam logic [LW-1:0] LMAX = LW'(FILT_CYCLES + 1);
   localparam logic [HW-1:0] HMAX = HW'(HOLD_CYCLES + 1);
   localparam logic [LW-1:0] LFILT = LW'(FILT_CYCLES);
   localparam logic [HW-1:0] HHOLD = HW'(HOLD_CYCLES);

   // Saturating run counters of consecutive low / good samples.
   logic [LW-1:0] low_run;
   logic [HW-1:0] high_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run  <= '0;
         high_run <= '0;
      end else if (sup_low) begin
         high_run <= '0;
         if (low_run != LMAX) low_run <= low_run + 1'b1;
      end else begin
         low_run <= '0;
         if (high_run != HMAX) high_run <= high_run + 1'b1;
      end
   end

   // R1: no release while the supply is low.
   p_stay_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sup_low && rst_act) |=> rst_act);

   // R2, R5 and R6: a release needs a full unbroken run of good samples.
   p_hold_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_act) |-> (high_run >= HHOLD));

   // R3: a short dip leaves a released output released.
   p_glitch_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!rst_act) && (low_run < LFILT)) |-> !rst_act);

   // R4: a dip of full window length forces reset.
   p_trip_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (low_run >= LFILT) |-> rst_act);

   // R7: pin sense follows the build option.
   p_polarity_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst == (ACTIVE_HIGH ? rst_act : !rst_act));

endmodule

bind supply_reset_seq supsv_checker #(
   .FILT_CYCLES (FILT_CYCLES),
   .HOLD_CYCLES (HOLD_CYCLES),
   .ACTIVE_HIGH (ACTIVE_HIGH)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sup_low (sup_low),
   .rst_act (rst_act),
   .sys_rst (sys_rst)
);

// File: tb/supply_reset_seq_bench.sv
module supply_reset_seq_bench;

   localparam int F = 4;
   localparam int H = 20;
   localparam realtime TCLK = 4ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sup_low = 1'b0;
   logic sys_rst_lo;
   logic sys_rst_hi;

   int n_cmp = 0;
   int n_bad = 0;
   bit done_flag = 1'b0;
   string phase = "R6 power-on";

   always #(TCLK / 2) clk = ~clk;

   supply_reset_seq #(.FILT_CYCLES(F), .HOLD_CYCLES(H), .ACTIVE_HIGH(1'b0)) u_supply_reset_seq (
      .clk(clk), .rst_n(rst_n), .sup_low(sup_low), .sys_rst(sys_rst_lo));

   supply_reset_seq #(.FILT_CYCLES(F), .HOLD_CYCLES(H), .ACTIVE_HIGH(1'b1)) u_supply_reset_seq_hi (
      .clk(clk), .rst_n(rst_n), .sup_low(sup_low), .sys_rst(sys_rst_hi));

   // Behavioural reference: is reset active, and the two run lengths.
   bit m_act = 1'b1;
   int m_low = 0;
   int m_good = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_act = 1'b1; m_low = 0; m_good = 0;
      end else if (m_act) begin
         m_low = 0;
         if (sup_low) m_good = 0;
         else begin
            m_good = m_good + 1;
            if (m_good == H) begin m_act = 1'b0; m_good = 0; end
         end
      end else begin
         m_good = 0;
         if (!sup_low) m_low = 0;
         else begin
            m_low = m_low + 1;
            if (m_low == F) begin m_act = 1'b1; m_low = 0; end
         end
      end
   end

   // Compare both variants on every falling edge (R7 covers the sense).
   always @(negedge clk) begin
      if (!done_flag) begin
         n_cmp = n_cmp + 1;
         if (sys_rst_lo !== !m_act) begin
            n_bad = n_bad + 1;
            $display("FAIL %s R7 active-low pin: actual %b expected %b at %0t",
                     phase, sys_rst_lo, !m_act, $time);
         end
         n_cmp = n_cmp + 1;
         if (sys_rst_hi !== m_act) begin
            n_bad = n_bad + 1;
            $display("FAIL %s R7 active-high pin: actual %b expected %b at %0t",
                     phase, sys_rst_hi, m_act, $time);
         end
      end
   end

   task automatic drive(input bit v, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
         sup_low = v;
      end
   endtask

   task automatic finish_run();
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(TCLK * 200000);
      n_bad = n_bad + 1;
      $display("FAIL watchdog expired in phase %s", phase);
      finish_run();
   end

   initial begin
      // R6: reset state, then the full timeout before release.
      drive(1'b0, 3);
      @(negedge clk); #1; rst_n = 1'b1;
      drive(1'b0, H + 10);

      phase = "R3 short dips";
      for (int d = 1; d < F; d++) begin
         drive(1'b1, d);
         drive(1'b0, 2);
      end

      phase = "R3 run cleared by one good sample";
      drive(1'b1, F - 1); drive(1'b0, 1); drive(1'b1, F - 1); drive(1'b0, 3);

      phase = "R4 dip of full window";
      drive(1'b1, F + 2);

      phase = "R1 held while low";
      drive(1'b1, H + 5);

      phase = "R5 dip during timeout";
      drive(1'b0, H - 2); drive(1'b1, 1); drive(1'b0, H + 5);

      phase = "R2 exact release edge";
      drive(1'b1, F); drive(1'b0, H - 1); drive(1'b0, 3);

      phase = "R6 reset asserted mid-run";
      @(negedge clk); #1; rst_n = 1'b0;
      drive(1'b0, 2);
      @(negedge clk); #1; rst_n = 1'b1;
      drive(1'b0, H + 5);

      phase = "R1 R2 R3 R4 R5 mixed pattern";
      for (int k = 0; k < 300; k++) begin
         drive(1'b1, 1 + ($urandom % (F + 2)));
         drive(1'b0, 1 + ($urandom % (H + 6)));
      end

      drive(1'b0, 2);
      finish_run();
   end

endmodule